// File: doc/BRIEF.md
# Channel chaining exception controller

This block decides what an I/O channel does when an operation ends or when fetching or saving channel state goes wrong. It watches the current chaining mode, the end of an operation, the fetch of each new channel command word (its address and its program-controlled-interrupt bit), the installed memory size, and two parity-fault inputs. It keeps a sticky channel status byte and sends one-cycle commands to the device control logic. In data chaining it tells the device to raise an end condition on its next data service request and hands over to end servicing. In command chaining it tells the device to raise a channel interrupt.

The block also holds a small interrupt flag register and one mask register per processor state. A flag becomes a taken interrupt only while the mask of the current state enables it, and the lowest pending index is reported.

Top module: `chain_exc_ctl`

## Requirements
- R1: With `chain_cmd`=0 (data chaining), an `op_end` pulse gives a one-cycle `dev_end_next` pulse and a one-cycle `end_svc` pulse on the clock edge after the one that samples it.
- R2: With `chain_cmd`=1 (command chaining), an `op_end` pulse gives a one-cycle `dev_raise_int` pulse one clock later, and no `end_svc`.
- R3: When `ccw_fetch` is high and `ccw_addr` >= `mem_size`, status bit 0 (program check) is set from the next cycle on. An address below `mem_size` sets nothing. `mem_size`=0 makes every address faulty.
- R4: `mm_parity_err` together with `ccw_fetch` sets status bit 1 (channel control check). `mm_parity_err` without `ccw_fetch` is ignored: no status change and no command.
- R5: `sp_parity_err` in any cycle sets status bit 1.
- R6: An address fault, a fetch parity fault or a scratch-pad parity fault gives, one clock later, `dev_end_next` when `chain_cmd`=0 and `dev_raise_int` when `chain_cmd`=1. Any number of events in one cycle give exactly one pulse. A cycle with no event gives no pulse. The two commands are never high together.
- R7: Status bits 0 and 1 stay set until `status_clr` is sampled high, and they read 0 from the next cycle. A set in the same cycle as the clear wins. Bits 7:2 always read 0.
- R8: `ccw_fetch` with `ccw_pci`=1 sets interrupt flag `PCI_BIT`. `flag_set[i]` sets flag i and `flag_clr[i]` clears it. A set wins over a clear in the same cycle. All of these take effect one cycle later.
- R9: `mask_we` writes `mask_wdata` into the mask of state `mask_wsel`. `int_take` is high, combinationally, when some flag is set and the mask of `cur_state` enables it. `int_sel` is then the lowest such index. A state at or above `NSTATE` has an all-zero mask.
- R10: While `rst_n` is low at a clock edge, all status bits, flags, masks and pulses are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_cmd | input | 1 | 1 = command chaining, 0 = data chaining |
| op_end | input | 1 | Operation end pulse |
| ccw_fetch | input | 1 | Next command word fetched |
| ccw_addr | input | AW | Main-memory address of the fetched word |
| ccw_pci | input | 1 | Program-controlled-interrupt bit of the fetched word |
| mem_size | input | AW+1 | Installed memory size in words |
| mm_parity_err | input | 1 | Main-memory parity fault during the fetch |
| sp_parity_err | input | 1 | Scratch-pad parity fault during subchannel save |
| status_clr | input | 1 | Clear the sticky status bits |
| flag_set | input | NFLAG | Set interrupt flags |
| flag_clr | input | NFLAG | Clear interrupt flags |
| mask_we | input | 1 | Mask write enable |
| mask_wsel | input | SW | State whose mask is written |
| mask_wdata | input | NFLAG | Mask value |
| cur_state | input | SW | Current processor state |
| status | output | 8 | Channel status byte |
| dev_end_next | output | 1 | Command: end on next data service request |
| dev_raise_int | output | 1 | Command: raise channel interrupt |
| end_svc | output | 1 | Hand-over to end servicing |
| int_take | output | 1 | An enabled interrupt is pending |
| int_sel | output | FW | Lowest enabled pending flag index |

## Verification
The bench builds the block with an 8-bit address, four flags and three processor states. The 9-bit size input can then cover the full range from zero to 256 words, so both ends of the address comparison can be tried. With three states, the select values 0 to 3 include one state with no mask register, which exercises the forced-zero mask. Random traffic with a short address range and small sizes makes faults on the same cycle and in both chain modes common.

// File: rtl/chain_exc_ctl.sv
module chain_exc_ctl #(
  parameter int AW      = 16,
  parameter int NFLAG   = 8,
  parameter int NSTATE  = 4,
  parameter int PCI_BIT = 0,
  localparam int SW = (NSTATE > 1) ? $clog2(NSTATE) : 1,
  localparam int FW = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chain_cmd,
  input  logic             op_end,
  input  logic             ccw_fetch,
  input  logic [AW-1:0]    ccw_addr,
  input  logic             ccw_pci,
  input  logic [AW:0]      mem_size,
  input  logic             mm_parity_err,
  input  logic             sp_parity_err,
  input  logic             status_clr,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic             mask_we,
  input  logic [SW-1:0]    mask_wsel,
  input  logic [NFLAG-1:0] mask_wdata,
  input  logic [SW-1:0]    cur_state,
  output logic [7:0]       status,
  output logic             dev_end_next,
  output logic             dev_raise_int,
  output logic             end_svc,
  output logic             int_take,
  output logic [FW-1:0]    int_sel
);

  logic             pchk_q, ccc_q;
  logic             endn_q, rint_q, svc_q;
  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] mask_q [NSTATE];
  logic [NFLAG-1:0] cur_mask, pend;

  wire addr_bad  = ccw_fetch && ({1'b0, ccw_addr} >= mem_size);
  wire fetch_par = ccw_fetch && mm_parity_err;
  wire any_evt   = op_end || addr_bad || fetch_par || sp_parity_err;

  wire [NFLAG-1:0] pci_set = (ccw_fetch && ccw_pci) ? (NFLAG'(1) << PCI_BIT) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pchk_q <= 1'b0;
      ccc_q  <= 1'b0;
      endn_q <= 1'b0;
      rint_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      pchk_q <= (pchk_q && !status_clr) || addr_bad;
      ccc_q  <= (ccc_q && !status_clr) || fetch_par || sp_parity_err;
      endn_q <= any_evt && !chain_cmd;
      rint_q <= any_evt && chain_cmd;
      svc_q  <= op_end && !chain_cmd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set | pci_set;
  end

  for (genvar s = 0; s < NSTATE; s++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)
        mask_q[s] <= '0;
      else if (mask_we && (32'(mask_wsel) == s))
        mask_q[s] <= mask_wdata;
    end
  end

  always_comb begin
    cur_mask = '0;
    for (int s = 0; s < NSTATE; s++)
      if (32'(cur_state) == s) cur_mask = mask_q[s];
  end

  assign pend = flags_q & cur_mask;

  always_comb begin
    int_sel = '0;
    for (int i = NFLAG - 1; i >= 0; i--)
      if (pend[i]) int_sel = FW'(i);
  end

  assign int_take      = |pend;
  assign status        = {6'b0, ccc_q, pchk_q};
  assign dev_end_next  = endn_q;
  assign dev_raise_int = rint_q;
  assign end_svc       = svc_q;

endmodule

module chain_exc_ctl_chk #(
  parameter int AW = 16,
  parameter int FW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chain_cmd,
  input logic          op_end,
  input logic          ccw_fetch,
  input logic [AW-1:0] ccw_addr,
  input logic [AW:0]   mem_size,
  input logic          mm_parity_err,
  input logic          sp_parity_err,
  input logic          status_clr,
  input logic [7:0]    status,
  input logic          dev_end_next,
  input logic          dev_raise_int,
  input logic          end_svc,
  input logic          int_take,
  input logic [FW-1:0] int_sel
);
  wire a_bad = ccw_fetch && ({1'b0, ccw_addr} >= mem_size);
  wire evt   = op_end || a_bad || (ccw_fetch && mm_parity_err) || sp_parity_err;

  AST_DATA_END: assert property (@(posedge clk) disable iff (!rst_n)
    op_end && !chain_cmd |=> dev_end_next && end_svc); // R1
  AST_CMD_INT: assert property (@(posedge clk) disable iff (!rst_n)
    op_end && chain_cmd |=> dev_raise_int && !end_svc); // R2
  AST_ADDR_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    a_bad |=> status[0]); // R3
  AST_FETCH_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    ccw_fetch && mm_parity_err |=> status[1]); // R4
  AST_SP_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    sp_parity_err |=> status[1]); // R5
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_end_next && dev_raise_int)); // R6
  AST_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> !dev_end_next && !dev_raise_int); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1:0] != 2'b00) && !status_clr |=> $past(status[1:0]) == (status[1:0] & $past(status[1:0]))); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:2] == 6'b0); // R7
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !int_take |-> int_sel == '0); // R9
endmodule

bind chain_exc_ctl chain_exc_ctl_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_cmd(chain_cmd), .op_end(op_end),
  .ccw_fetch(ccw_fetch), .ccw_addr(ccw_addr), .mem_size(mem_size),
  .mm_parity_err(mm_parity_err), .sp_parity_err(sp_parity_err),
  .status_clr(status_clr), .status(status), .dev_end_next(dev_end_next),
  .dev_raise_int(dev_raise_int), .end_svc(end_svc), .int_take(int_take),
  .int_sel(int_sel)
);

// File: tb/chain_exc_ctl_test.sv
`timescale 1ns/1ps
module chain_exc_ctl_test;
  localparam int AW = 8, NF = 4, NS = 3, SW = 2, FW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic chain_cmd = 0, op_end = 0, ccw_fetch = 0, ccw_pci = 0;
  logic [AW-1:0] ccw_addr = 0;
  logic [AW:0] mem_size = 9'd256;
  logic mm_parity_err = 0, sp_parity_err = 0, status_clr = 0, mask_we = 0;
  logic [NF-1:0] flag_set = 0, flag_clr = 0, mask_wdata = 0;
  logic [SW-1:0] mask_wsel = 0, cur_state = 0;
  logic [7:0] status;
  logic dev_end_next, dev_raise_int, end_svc, int_take;
  logic [FW-1:0] int_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_pchk, m_ccc, m_endn, m_rint, m_svc;
  bit [NF-1:0] m_flags;
  bit [NF-1:0] m_mask [NS];

  always #2.5 clk = ~clk;

  chain_exc_ctl #(.AW(AW), .NFLAG(NF), .NSTATE(NS), .PCI_BIT(0)) uut (
    .clk(clk), .rst_n(rst_n), .chain_cmd(chain_cmd), .op_end(op_end),
    .ccw_fetch(ccw_fetch), .ccw_addr(ccw_addr), .ccw_pci(ccw_pci),
    .mem_size(mem_size), .mm_parity_err(mm_parity_err),
    .sp_parity_err(sp_parity_err), .status_clr(status_clr),
    .flag_set(flag_set), .flag_clr(flag_clr), .mask_we(mask_we),
    .mask_wsel(mask_wsel), .mask_wdata(mask_wdata), .cur_state(cur_state),
    .status(status), .dev_end_next(dev_end_next), .dev_raise_int(dev_raise_int),
    .end_svc(end_svc), .int_take(int_take), .int_sel(int_sel));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit ab, fp, ev;
    if (!rst_n) begin
      m_pchk = 0; m_ccc = 0; m_endn = 0; m_rint = 0; m_svc = 0; m_flags = 0;
      for (int s = 0; s < NS; s++) m_mask[s] = 0;
      return;
    end
    ab = ccw_fetch && (int'(ccw_addr) >= int'(mem_size));
    fp = ccw_fetch && mm_parity_err;
    ev = op_end || ab || fp || sp_parity_err;
    m_endn = ev && !chain_cmd;
    m_rint = ev && chain_cmd;
    m_svc  = op_end && !chain_cmd;
    m_pchk = (m_pchk && !status_clr) || ab;
    m_ccc  = (m_ccc && !status_clr) || fp || sp_parity_err;
    for (int i = 0; i < NF; i++) begin
      if (flag_clr[i]) m_flags[i] = 0;
      if (flag_set[i] || (i == 0 && ccw_fetch && ccw_pci)) m_flags[i] = 1;
    end
    if (mask_we && int'(mask_wsel) < NS) m_mask[mask_wsel] = mask_wdata;
  endtask

  task automatic compare();
    bit [NF-1:0] p;
    int sel;
    p = (int'(cur_state) < NS) ? (m_flags & m_mask[cur_state]) : '0;
    sel = 0;
    for (int i = NF - 1; i >= 0; i--) if (p[i]) sel = i;
    check("R1 R6 R10 dev_end_next", dev_end_next, m_endn);
    check("R2 R6 R10 dev_raise_int", dev_raise_int, m_rint);
    check("R1 R2 end_svc", end_svc, m_svc);
    check("R3 R4 R5 R7 R10 status", status, {6'b0, m_ccc, m_pchk});
    check("R8 R9 int_take", int_take, p != 0);
    check("R9 int_sel", int_sel, sel);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    op_end = 0; ccw_fetch = 0; ccw_pci = 0; mm_parity_err = 0;
    sp_parity_err = 0; status_clr = 0; mask_we = 0; flag_set = 0; flag_clr = 0;
  endtask

  initial begin
    @(negedge clk);
    tick(); tick();
    check("R10 status after reset", status, 0);
    check("R10 int_take after reset", int_take, 0);
    rst_n = 1;

    chain_cmd = 0; op_end = 1; tick(); quiet();
    check("R1 end_next", dev_end_next, 1);
    check("R1 end_svc", end_svc, 1);
    tick();
    check("R1 single pulse", dev_end_next, 0);

    chain_cmd = 1; op_end = 1; tick(); quiet();
    check("R2 raise_int", dev_raise_int, 1);
    check("R2 no end_svc", end_svc, 0);

    mem_size = 9'd100; chain_cmd = 0;
    ccw_fetch = 1; ccw_addr = 8'd99; tick(); quiet();
    check("R3 addr below size", status, 0);
    check("R6 no pulse on good fetch", dev_end_next, 0);
    ccw_fetch = 1; ccw_addr = 8'd100; tick(); quiet();
    check("R3 addr at size", status, 1);
    check("R6 data chain fault", dev_end_next, 1);
    tick(); tick();
    check("R7 sticky", status, 1);
    status_clr = 1; tick(); quiet();
    check("R7 cleared", status, 0);

    chain_cmd = 1; ccw_fetch = 1; ccw_addr = 8'd5; mm_parity_err = 1; tick(); quiet();
    check("R4 fetch parity", status, 2);
    check("R6 cmd chain fault", dev_raise_int, 1);
    status_clr = 1; tick(); quiet();

    mm_parity_err = 1; tick(); quiet();
    check("R4 parity without fetch ignored", status, 0);
    check("R4 no pulse without fetch", dev_raise_int, 0);

    chain_cmd = 0; sp_parity_err = 1; tick(); quiet();
    check("R5 scratch-pad parity", status, 2);
    check("R6 sp fault data chain", dev_end_next, 1);

    chain_cmd = 1; op_end = 1; ccw_fetch = 1; ccw_addr = 8'd200;
    mm_parity_err = 1; sp_parity_err = 1; tick(); quiet();
    check("R6 all faults bits", status, 3);
    check("R6 one pulse", dev_raise_int + dev_end_next, 1);
    tick();
    check("R6 pulse ends", dev_raise_int, 0);

    status_clr = 1; sp_parity_err = 1; tick(); quiet();
    check("R7 set wins over clear", status, 2);
    status_clr = 1; tick(); quiet();

    mem_size = 0; ccw_fetch = 1; ccw_addr = 0; tick(); quiet();
    check("R3 zero size faults", status, 1);
    mem_size = 9'd256; ccw_fetch = 1; ccw_addr = 8'd255; status_clr = 1; tick(); quiet();
    check("R3 full size no fault", status, 0);

    ccw_fetch = 1; ccw_pci = 1; ccw_addr = 1; cur_state = 0;
    mask_we = 1; mask_wsel = 1; mask_wdata = 4'b0001; tick(); quiet();
    check("R8 R9 masked in state 0", int_take, 0);
    cur_state = 1; #0.1;
    check("R9 taken in state 1", int_take, 1);
    check("R9 sel", int_sel, 0);
    cur_state = 3; #0.1;
    check("R9 state without mask", int_take, 0);
    cur_state = 1; flag_clr = 4'b0001; flag_set = 4'b0001; tick(); quiet();
    check("R8 set wins", int_take, 1);
    flag_clr = 4'b0001; tick(); quiet();
    check("R8 cleared", int_take, 0);

    for (int n = 0; n < 6000; n++) begin
      rst_n         = ($urandom_range(0, 199) != 0);
      chain_cmd     = $urandom_range(0, 1);
      op_end        = ($urandom_range(0, 5) == 0);
      ccw_fetch     = ($urandom_range(0, 2) == 0);
      ccw_addr      = 8'($urandom_range(0, 40));
      ccw_pci       = $urandom_range(0, 1);
      if ($urandom_range(0, 30) == 0) mem_size = 9'($urandom_range(0, 256));
      mm_parity_err = ($urandom_range(0, 6) == 0);
      sp_parity_err = ($urandom_range(0, 9) == 0);
      status_clr    = ($urandom_range(0, 7) == 0);
      flag_set      = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0;
      flag_clr      = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0;
      mask_we       = ($urandom_range(0, 5) == 0);
      mask_wsel     = 2'($urandom);
      mask_wdata    = 4'($urandom);
      cur_state     = 2'($urandom);
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule